// File: doc/BRIEF.md
# Two-Wire Slave Command Interface for a Dual Potentiometer and Comparator Controller

This block is the serial front end of a controller for two digital potentiometers and two comparators. It watches an oversampled two-wire bus made of a clock line and a data line, and pulls the data line low through an open-drain output. It recognises START and STOP conditions. It accepts an address byte that combines a fixed type code with four strap pins. It then decodes an instruction byte and turns each accepted command into a single-cycle request to a separate register bank.

Each unit (wiper 0, wiper 1, comparator control 0, comparator control 1) has one live register and four stored data registers. The bank executes every request. The bank also supplies read data for the register named by the held instruction fields, and the block shifts that data out MSB first. When the bank raises its busy flag, the address byte is not acknowledged, so a master can poll until the nonvolatile write has finished. In step mode, every clock pulse on the bus moves the selected wiper one tap up or down.

The controller has the states ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INSTR, ST_INSTR_ACK, ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RD_MACK, ST_STEP and ST_IGNORE. Two transitions apply in every state:
- A START moves the controller to ST_ADDR.
- A STOP moves it to ST_IDLE.

The other transitions are:
- **ST_ADDR**: after eight bits it goes to ST_ADDR_ACK on a match, or to ST_IGNORE on a mismatch.
- **ST_ADDR_ACK**: it goes to ST_INSTR.
- **ST_INSTR**: it goes to ST_INSTR_ACK for a valid opcode, or to ST_IGNORE for an unused one.
- **ST_INSTR_ACK**, by instruction class:
  - a transfer goes to ST_IGNORE,
  - a write goes to ST_WDATA,
  - a read goes to ST_RDATA,
  - a step goes to ST_STEP.
- **ST_WDATA**: it goes to ST_WDATA_ACK.
- **ST_WDATA_ACK**: it goes to ST_IGNORE.
- **ST_RDATA**: it goes to ST_RD_MACK.
- **ST_RD_MACK**: it goes to ST_IGNORE.

Top module: `pot_link_slave`

## Requirements
- R1: A START condition (data falling while the clock is high) in any state restarts address reception. A STOP condition (data rising while the clock is high) returns the block to idle with the data line released.
- R2: The address byte is acknowledged, by pulling the data line low for the ninth clock, only when its bits 7:4 are 0101 and its bits 3:0 equal the strap inputs. A mismatch gets no acknowledge, and the block stays silent until the next START.
- R3: While busy is high, the address byte is not acknowledged. A later START with the same address is acknowledged once busy is low.
- R4: In the instruction byte, bits 7:4 are the opcode, bits 3:2 are the stored-register index (presented on req_reg) and bits 1:0 are the unit index (presented on req_unit). Every valid opcode is acknowledged.
- R5: The opcodes 0000, 0011..0111 and 1111 are not acknowledged. After one of them, no later byte is acknowledged and no request is issued until the next START or STOP.
- R6: Opcode 1010 (write live, req_kind 1) and opcode 1100 (write stored, req_kind 2) take a third byte. That byte is acknowledged, and one request carries its bits 5:0 on req_data. Any further byte is not acknowledged.
- R7: Opcode 1001 (read live, view_dr low) and opcode 1011 (read stored, view_dr high) send eight bits MSB first: two zero bits, then the six-bit value from rd_data. Each bit is driven after a clock fall, and the data line is released for the master's acknowledge bit.
- R8: Each transfer opcode issues one request after the instruction acknowledge and accepts no further byte. The four transfers are:
  - 1101: stored to live, req_kind 3.
  - 1110: live to stored, req_kind 4.
  - 0001: all units stored to live, req_kind 5.
  - 1000: all units live to stored, req_kind 6.
- R9: In step mode (opcode 0010), each complete clock pulse issues one request after the clock falls. The data level at the rising edge sets the direction: high gives req_kind 7 (up) and low gives req_kind 8 (down). A pulse ended by a STOP issues nothing.
- R10: req_valid is high for exactly one cycle per request, and each request carries a non-zero req_kind.
- R11: sda_pull changes only in the cycle after the synchronised clock is low, except for the release forced by a START or a STOP.
- R12: After reset, sda_pull and req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as sampled |
| sda_in | input | 1 | Bus data line as sampled (wired level) |
| sda_pull | output | 1 | 1 pulls the data line low |
| strap | input | 4 | Address strap pins, compared with address bits 3:0 |
| busy | input | 1 | Bank write in progress; blocks the address acknowledge |
| rd_data | input | 6 | Value of the register selected by req_unit, req_reg and view_dr |
| view_dr | output | 1 | 1 selects the stored register for rd_data |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 4 | Request code (1..8, see R6, R8, R9) |
| req_unit | output | 2 | Unit index from instruction bits 1:0 |
| req_reg | output | 2 | Stored-register index from instruction bits 3:2 |
| req_data | output | 6 | Write data for req_kind 1 and 2 |

## Verification
The main command path is exercised with the following patterns, each aimed at a different kind of fault:
- Writes followed by reads of distinct values in the live and stored registers of several units. These expose swapped fields and wrong source selection.
- Data bytes with their top two bits set, which show whether only the low six bits are kept.
- Every transfer and global transfer, each checked through a later readback.
- A step stream mixing up and down pulses that ends in a STOP.

Addresses with a wrong type code or a wrong strap, unused opcodes, busy polling and a START in the middle of an instruction byte separate refusal from acceptance. The bench's register model is updated from every request it observes and is compared with the expected request queue on every clock. As a result, both extra requests and missing requests are reported.

// File: rtl/pl_pkg.sv
package pl_pkg;

    typedef enum logic [3:0] {
        RQ_NONE           = 4'd0,
        RQ_WR_LIVE        = 4'd1,
        RQ_WR_DR          = 4'd2,
        RQ_DR_TO_LIVE     = 4'd3,
        RQ_LIVE_TO_DR     = 4'd4,
        RQ_ALL_DR_TO_LIVE = 4'd5,
        RQ_ALL_LIVE_TO_DR = 4'd6,
        RQ_STEP_UP        = 4'd7,
        RQ_STEP_DN        = 4'd8
    } req_kind_t;

    typedef enum logic [2:0] {
        CL_BAD,
        CL_XFER,
        CL_WRITE,
        CL_READ_LIVE,
        CL_READ_DR,
        CL_STEP
    } op_class_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_MACK,
        ST_STEP,
        ST_IGNORE
    } state_t;

endpackage

// File: rtl/pl_bus_sense.sv
module pl_bus_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_d;
    logic              sda_d;

    // bus idles high, so the chain resets high and no event fires out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_lvl  = scl_sh[STAGES-1];
    assign sda_lvl  = sda_sh[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_d;
    assign scl_fall = ~scl_lvl & scl_d;
    assign start_ev = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/pl_opcode_decode.sv
module pl_opcode_decode
    import pl_pkg::*;
(
    input  logic [3:0] opcode,
    output op_class_t  cls,
    output req_kind_t  kind
);
    always_comb begin
        cls  = CL_BAD;
        kind = RQ_NONE;
        case (opcode)
            4'b1001: cls = CL_READ_LIVE;
            4'b1011: cls = CL_READ_DR;
            4'b1010: begin cls = CL_WRITE; kind = RQ_WR_LIVE;        end
            4'b1100: begin cls = CL_WRITE; kind = RQ_WR_DR;          end
            4'b1101: begin cls = CL_XFER;  kind = RQ_DR_TO_LIVE;     end
            4'b1110: begin cls = CL_XFER;  kind = RQ_LIVE_TO_DR;     end
            4'b0001: begin cls = CL_XFER;  kind = RQ_ALL_DR_TO_LIVE; end
            4'b1000: begin cls = CL_XFER;  kind = RQ_ALL_LIVE_TO_DR; end
            4'b0010: cls = CL_STEP;
            default: begin cls = CL_BAD;   kind = RQ_NONE;           end
        endcase
    end

endmodule

// File: rtl/pot_link_slave.sv
module pot_link_slave
    import pl_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         ADDR_W      = 4,
    parameter int         DATA_W      = 6,
    parameter logic [3:0] TYPE_CODE   = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [ADDR_W-1:0] strap,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              view_dr,
    output logic              req_valid,
    output logic [3:0]        req_kind,
    output logic [1:0]        req_unit,
    output logic [1:0]        req_reg,
    output logic [DATA_W-1:0] req_data
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int PAD_W  = BYTE_W - DATA_W;
    localparam int TYPE_W = BYTE_W - ADDR_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    pl_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    state_t              state_q, state_n;
    logic [CNT_W-1:0]    cnt_q, cnt_n;
    logic [BYTE_W-1:0]   sh_q, sh_n;
    logic [BYTE_W-1:0]   instr_q, instr_n;
    logic                pull_q, pull_n;
    logic                pend_q, pend_n;
    logic                dir_q, dir_n;
    logic                rv_q, rv_n;
    req_kind_t           rk_q, rk_n;
    logic [DATA_W-1:0]   rdat_q, rdat_n;

    op_class_t           dec_cls;
    req_kind_t           dec_kind;
    logic [3:0]          dec_op;
    logic [BYTE_W-1:0]   rd_word;
    logic                addr_hit;

    // while the instruction is arriving decode the shift register, otherwise the held byte
    assign dec_op = (state_q == ST_INSTR) ? sh_q[BYTE_W-1 -: 4] : instr_q[BYTE_W-1 -: 4];

    pl_opcode_decode u_dec (
        .opcode (dec_op),
        .cls    (dec_cls),
        .kind   (dec_kind)
    );

    assign rd_word  = {{PAD_W{1'b0}}, rd_data};
    assign addr_hit = (sh_q[BYTE_W-1 -: TYPE_W] == TYPE_CODE) &&
                      (sh_q[ADDR_W-1:0] == strap) && !busy;

    // state and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            instr_q <= '0;
            pull_q  <= 1'b0;
            pend_q  <= 1'b0;
            dir_q   <= 1'b0;
            rv_q    <= 1'b0;
            rk_q    <= RQ_NONE;
            rdat_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            sh_q    <= sh_n;
            instr_q <= instr_n;
            pull_q  <= pull_n;
            pend_q  <= pend_n;
            dir_q   <= dir_n;
            rv_q    <= rv_n;
            rk_q    <= rk_n;
            rdat_q  <= rdat_n;
        end
    end

    // next state and next outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        instr_n = instr_q;
        pull_n  = pull_q;
        pend_n  = pend_q;
        dir_n   = dir_q;
        rv_n    = 1'b0;
        rk_n    = RQ_NONE;
        rdat_n  = rdat_q;

        if (start_ev) begin
            state_n = ST_ADDR;
            cnt_n   = '0;
            pull_n  = 1'b0;
            pend_n  = 1'b0;
        end else if (stop_ev) begin
            state_n = ST_IDLE;
            pull_n  = 1'b0;
            pend_n  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_ADDR, ST_INSTR, ST_WDATA: begin
                    if (scl_rise && cnt_q != FULL) begin
                        sh_n  = {sh_q[BYTE_W-2:0], sda_lvl};
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL) begin
                        if (state_q == ST_ADDR) begin
                            if (addr_hit) begin
                                state_n = ST_ADDR_ACK;
                                pull_n  = 1'b1;
                            end else begin
                                state_n = ST_IGNORE;
                            end
                        end else if (state_q == ST_INSTR) begin
                            instr_n = sh_q;
                            if (dec_cls != CL_BAD) begin
                                state_n = ST_INSTR_ACK;
                                pull_n  = 1'b1;
                            end else begin
                                state_n = ST_IGNORE;
                            end
                        end else begin
                            rv_n    = 1'b1;
                            rk_n    = dec_kind;
                            rdat_n  = sh_q[DATA_W-1:0];
                            state_n = ST_WDATA_ACK;
                            pull_n  = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        pull_n  = 1'b0;
                        cnt_n   = '0;
                        state_n = ST_INSTR;
                    end
                end
                ST_INSTR_ACK: begin
                    if (scl_fall) begin
                        pull_n = 1'b0;
                        cnt_n  = '0;
                        unique case (dec_cls)
                            CL_XFER: begin
                                rv_n    = 1'b1;
                                rk_n    = dec_kind;
                                state_n = ST_IGNORE;
                            end
                            CL_WRITE: state_n = ST_WDATA;
                            CL_READ_LIVE, CL_READ_DR: begin
                                sh_n    = rd_word;
                                pull_n  = ~rd_word[BYTE_W-1];
                                state_n = ST_RDATA;
                            end
                            CL_STEP: state_n = ST_STEP;
                            CL_BAD:  state_n = ST_IGNORE;
                        endcase
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        pull_n  = 1'b0;
                        state_n = ST_IGNORE;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == FULL) begin
                            pull_n  = 1'b0;
                            state_n = ST_RD_MACK;
                        end else begin
                            pull_n = ~sh_q[BYTE_W-2];
                            sh_n   = {sh_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_MACK: begin
                    if (scl_rise) state_n = ST_IGNORE;
                end
                ST_STEP: begin
                    if (scl_rise) begin
                        pend_n = 1'b1;
                        dir_n  = sda_lvl;
                    end else if (scl_fall && pend_q) begin
                        pend_n = 1'b0;
                        rv_n   = 1'b1;
                        rk_n   = dir_q ? RQ_STEP_UP : RQ_STEP_DN;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    assign sda_pull  = pull_q;
    assign req_valid = rv_q;
    assign req_kind  = rk_q;
    assign req_data  = rdat_q;
    assign req_unit  = instr_q[1:0];
    assign req_reg   = instr_q[3:2];
    assign view_dr   = (dec_cls == CL_READ_DR);

endmodule

// File: rtl/pl_slave_chk.sv
module pl_slave_chk
    import pl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull,
    input logic       scl_lvl,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       busy,
    input logic       req_valid,
    input logic [3:0] req_kind,
    input state_t     state
);
    // R10
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R10
    kind_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind != 4'd0));

    // R3
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ADDR && state == ST_ADDR_ACK) |-> !$past(busy));

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_ev) |-> (!sda_pull && state == ST_IDLE));

    // R1
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_ev) |-> (state == ST_ADDR && !sda_pull));

    // R11
    pull_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> (!$past(scl_lvl) || $past(start_ev) || $past(stop_ev)));

    // R5
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull);

endmodule

bind pot_link_slave pl_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_pull  (sda_pull),
    .scl_lvl   (scl_lvl),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .busy      (busy),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .state     (state_q)
);

// File: tb/test_pot_link_slave.sv
module test_pot_link_slave;
    import pl_pkg::*;

    localparam int Q = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'hA;
    logic       busy  = 1'b0;
    logic       sda_pull, view_dr, req_valid;
    logic [3:0] req_kind;
    logic [1:0] req_unit, req_reg;
    logic [5:0] req_data, rd_data;
    logic       sda_bus;

    assign sda_bus = sda_m & ~sda_pull;

    // register bank model
    logic [5:0] live [4];
    logic [5:0] dr   [4][4];
    assign rd_data = view_dr ? dr[req_unit][req_reg] : live[req_unit];

    pot_link_slave i_pot_link_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_pull(sda_pull), .strap(strap), .busy(busy), .rd_data(rd_data),
        .view_dr(view_dr), .req_valid(req_valid), .req_kind(req_kind),
        .req_unit(req_unit), .req_reg(req_reg), .req_data(req_data)
    );

    typedef struct {
        int    k;
        int    u;
        int    r;
        int    d;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    logic prev_rv = 1'b0;
    logic done = 1'b0;

    task automatic chk_eq(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic expect_req(input int k, input int u, input int r, input int d, input string tag);
        exp_t e;
        e.k = k; e.u = u; e.r = r; e.d = d; e.tag = tag;
        q.push_back(e);
    endtask

    // per-clock comparison of requests against the expected queue
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            chk_eq("R10 strobe longer than one cycle", int'(prev_rv), 0);
            if (q.size() == 0) begin
                chk_eq("R10 unexpected request kind", int'(req_kind), 0);
            end else begin
                exp_t e;
                int   act;
                int   expv;
                e    = q.pop_front();
                act  = int'(req_kind) * 4096 + int'(req_unit) * 1024 + int'(req_reg) * 256;
                expv = e.k * 4096 + e.u * 1024 + e.r * 256;
                if (e.k == 1 || e.k == 2) begin
                    act  = act + int'(req_data);
                    expv = expv + e.d;
                end
                chk_eq(e.tag, act, expv);
            end
            case (req_kind)
                4'd1: live[req_unit] = req_data;
                4'd2: dr[req_unit][req_reg] = req_data;
                4'd3: live[req_unit] = dr[req_unit][req_reg];
                4'd4: dr[req_unit][req_reg] = live[req_unit];
                4'd5: for (int u = 0; u < 4; u++) live[u] = dr[u][req_reg];
                4'd6: for (int u = 0; u < 4; u++) dr[u][req_reg] = live[u];
                4'd7: if (live[req_unit] != 6'd63) live[req_unit] = live[req_unit] + 6'd1;
                4'd8: if (live[req_unit] != 6'd0)  live[req_unit] = live[req_unit] - 6'd1;
                default: ;
            endcase
        end
        prev_rv = req_valid;
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(2 * Q);
    endtask

    task automatic m_bit(input logic b);
        w(Q); sda_m = b;
        w(Q); scl_m = 1'b1;
        w(2 * Q); scl_m = 1'b0;
    endtask

    task automatic m_getbit(output logic b);
        w(Q); sda_m = 1'b1;
        w(Q); scl_m = 1'b1;
        w(Q); b = sda_bus;
        w(Q); scl_m = 1'b0;
    endtask

    task automatic m_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
        m_getbit(a);
        ack = ~a;
    endtask

    task automatic m_read(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_getbit(v[i]);
        m_bit(1'b1);
    endtask

    task automatic read_reg(input logic [7:0] instr, input int expv, input string tag);
        logic       a;
        logic [7:0] v;
        m_start();
        m_byte(8'h5A, a);
        m_byte(instr, a);
        chk_eq({tag, " instruction ack"}, int'(a), 1);
        m_read(v);
        chk_eq(tag, int'(v), expv);
        m_stop();
    endtask

    task automatic write_reg(input logic [7:0] instr, input logic [7:0] d,
                             input int k, input string tag);
        logic a;
        m_start();
        m_byte(8'h5A, a);
        chk_eq({tag, " address ack"}, int'(a), 1);
        m_byte(instr, a);
        chk_eq({tag, " instruction ack"}, int'(a), 1);
        expect_req(k, int'(instr[1:0]), int'(instr[3:2]), int'(d[5:0]), tag);
        m_byte(d, a);
        chk_eq({tag, " data ack"}, int'(a), 1);
        m_byte(8'h00, a);
        chk_eq({tag, " extra byte refused"}, int'(a), 0);
        m_stop();
    endtask

    task automatic xfer(input logic [7:0] instr, input int k, input int u, input string tag);
        logic a;
        m_start();
        m_byte(8'h5A, a);
        expect_req(k, u, int'(instr[3:2]), 0, tag);
        m_byte(instr, a);
        chk_eq({tag, " instruction ack"}, int'(a), 1);
        m_byte(8'h15, a);
        chk_eq({tag, " no byte after transfer"}, int'(a), 0);
        m_stop();
    endtask

    initial begin
        for (int u = 0; u < 4; u++) begin
            live[u] = 6'(10 + u);
            for (int r = 0; r < 4; r++) dr[u][r] = 6'(u * 4 + r + 1);
        end
    end

    initial begin
        logic a;
        logic [7:0] v;
        w(5);
        chk_eq("R12 sda_pull after reset", int'(sda_pull), 0);
        chk_eq("R12 req_valid after reset", int'(req_valid), 0);
        rst_n = 1'b1;
        w(4);
        chk_eq("R12 sda_pull released", int'(sda_pull), 0);

        // R6 / R7: write then read back live and stored registers
        write_reg(8'hA0, 8'h2A, 1, "R6 write live unit0");
        read_reg(8'h90, 8'h2A, "R7 read live unit0");
        write_reg(8'hC9, 8'h15, 2, "R6 write stored unit1 reg2");
        read_reg(8'hB9, 8'h15, "R7 read stored unit1 reg2");
        write_reg(8'hA2, 8'hFF, 1, "R6 write live unit2 top bits dropped");
        read_reg(8'h92, 8'h3F, "R7 read live unit2");

        // R8: transfers
        xfer(8'hD9, 3, 1, "R8 stored to live unit1");
        read_reg(8'h91, 8'h15, "R8 live unit1 after transfer");
        xfer(8'hE4, 4, 0, "R8 live to stored unit0 reg1");
        read_reg(8'hB4, 8'h2A, "R8 stored unit0 reg1");
        xfer(8'h8C, 6, 0, "R8 global live to stored reg3");
        read_reg(8'hBE, 8'h3F, "R8 stored unit2 reg3");
        xfer(8'h18, 5, 0, "R8 global stored to live reg2");
        read_reg(8'h90, 8'h03, "R8 live unit0 after global");
        read_reg(8'h93, 8'h0F, "R4 live unit3 after global");

        // R2: address mismatches
        m_start();
        m_byte(8'h5B, a);
        chk_eq("R2 strap mismatch refused", int'(a), 0);
        m_byte(8'hA0, a);
        chk_eq("R2 silent after mismatch", int'(a), 0);
        m_stop();
        m_start();
        m_byte(8'h6A, a);
        chk_eq("R2 type code mismatch refused", int'(a), 0);
        m_stop();

        // R3: busy polling
        busy = 1'b1;
        m_start();
        m_byte(8'h5A, a);
        chk_eq("R3 busy address refused", int'(a), 0);
        busy = 1'b0;
        m_start();
        m_byte(8'h5A, a);
        chk_eq("R3 poll accepted", int'(a), 1);
        m_byte(8'h90, a);
        m_read(v);
        chk_eq("R3 read after poll", int'(v), 3);
        m_stop();

        // R5: unused opcodes
        m_start();
        m_byte(8'h5A, a);
        m_byte(8'h30, a);
        chk_eq("R5 opcode 0011 refused", int'(a), 0);
        m_byte(8'h2A, a);
        chk_eq("R5 later byte refused", int'(a), 0);
        m_stop();
        m_start();
        m_byte(8'h5A, a);
        m_byte(8'hF0, a);
        chk_eq("R5 opcode 1111 refused", int'(a), 0);
        m_stop();
        read_reg(8'h90, 8'h03, "R5 live unit0 unchanged");

        // R9: step stream
        m_start();
        m_byte(8'h5A, a);
        m_byte(8'h20, a);
        chk_eq("R9 step instruction ack", int'(a), 1);
        expect_req(7, 0, 0, 0, "R9 step up 1");
        m_bit(1'b1);
        expect_req(7, 0, 0, 0, "R9 step up 2");
        m_bit(1'b1);
        expect_req(8, 0, 0, 0, "R9 step down");
        m_bit(1'b0);
        m_stop();
        read_reg(8'h90, 8'h04, "R9 live unit0 after steps");

        // R1: START in the middle of an instruction byte
        m_start();
        m_byte(8'h5A, a);
        m_bit(1'b1); m_bit(1'b0); m_bit(1'b1); m_bit(1'b0);
        m_start();
        m_byte(8'h5A, a);
        chk_eq("R1 restart address ack", int'(a), 1);
        m_byte(8'h91, a);
        chk_eq("R1 restart instruction ack", int'(a), 1);
        m_read(v);
        chk_eq("R1 read after restart", int'(v), 8'h15);
        m_stop();
        chk_eq("R1 released after stop", int'(sda_pull), 0);

        w(20);
        chk_eq("R10 all expected requests seen", q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule